// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards a clock-frequency change. Software sets the enable and picks a timeout before it retunes the clock. Once an accepted frequency-change event arrives, the block counts down in units of either a short or a long prescaled interval. If software does not disable the watchdog before the count runs out, the block does four things. It raises a sticky timeout flag. It can issue a system reset pulse. It selects a recovery frequency source. It locks itself so that later frequency-change requests are refused.

The lock is released only by clearing the enable. Clearing the enable also stops the timer and reloads it. The source of the recovery frequency is chosen at expiry: either the frequency code latched from the board straps, or the software-programmed divider pair. The actual retune of the PLL happens outside this block. This block only produces the source selection and the accept/refuse decision for change requests.

Top module: `freq_watchdog`

## Requirements
- R1: After reset, `tmo_status`, `recov_lock` and `rst_req` are 0, `freq_src` is 2'b00 (normal), and a change request is passed straight to `chg_go`.
- R2: The countdown runs only after a change request is accepted while `wd_en` is 1. With no accepted change, or with a change made while `wd_en` is 0, no timeout ever occurs.
- R3: A timeout value v gives v+1 units. A unit is SHORT_UNIT_CYC clock cycles when `long_unit` is 0 and LONG_UNIT_CYC cycles when it is 1. `tmo_status` first reads 1 exactly (v+1)·unit cycles after the clock edge that sampled the accepted change.
- R4: `tmo_status` is sticky. A status write (`stat_wr`=1) with `stat_wdata`=1 clears it, and a write with `stat_wdata`=0 leaves it unchanged. If a write and an expiry fall in the same cycle, the expiry wins.
- R5: At expiry, `rst_req` goes high in the same cycle as `tmo_status` and stays high for exactly RST_PULSE_CYC cycles. This happens only when `rst_on_expire` is 1. Otherwise `rst_req` stays 0.
- R6: At expiry, `freq_src` becomes 2'b10 (latched strap code) if `recov_from_regs` is 0, and 2'b11 (programmed divider pair) if it is 1.
- R7: After expiry, `recov_lock` is 1 and `chg_go` stays 0 whatever the value of `chg_req`.
- R8: Setting `wd_en` to 0 clears `recov_lock`, returns `freq_src` to 2'b00, and stops and reloads the timer, all at the next edge. It leaves `tmo_status` unchanged.
- R9: If `wd_en` is cleared in the cycle in which the count would expire, the clear wins: no status, no lock and no reset pulse.
- R10: A change accepted while the countdown is running restarts it. The full (v+1)-unit interval is then measured from the new change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_en | input | 1 | Watchdog enable; 0 stops, reloads and unlocks |
| long_unit | input | 1 | Unit select: 0 short, 1 long |
| tmo_val | input | TMO_W | Timeout count v (v+1 units) |
| rst_on_expire | input | 1 | Issue a reset pulse on expiry |
| recov_from_regs | input | 1 | Recovery source: 0 strap code, 1 programmed pair |
| chg_req | input | 1 | Frequency-change request |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Status write data (1 clears) |
| chg_go | output | 1 | Change request accepted |
| tmo_status | output | 1 | Sticky timeout flag |
| rst_req | output | 1 | System reset request pulse |
| recov_lock | output | 1 | Recovery mode lock |
| freq_src | output | 2 | Frequency source: 00 normal, 10 strap, 11 programmed |

## Verification
The sweep covers every timeout value under both unit lengths, which separates an off-by-one in the count from an off-by-one in the prescaler. The reset and source options are tied to bits of the timeout value, so every combination of those options is tried. Separate cases cover the remaining behaviour:
- an enable clear that lands exactly on the expiry cycle;
- a second change that arrives mid-count;
- long idle stretches with no accepted change.

Each of these would be missed by a plain expiry test.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

    typedef enum logic [1:0] {
        CD_IDLE = 2'd0,
        CD_RUN  = 2'd1,
        CD_HOLD = 2'd2
    } cd_state_e;

    typedef enum logic [1:0] {
        SRC_NORMAL = 2'b00,
        SRC_STRAP  = 2'b10,
        SRC_PROG   = 2'b11
    } freq_src_e;

    typedef struct packed {
        logic status;
        logic locked;
        freq_src_e src;
    } recov_state_t;

    function automatic freq_src_e pick_recovery(input logic from_regs);
        return from_regs ? SRC_PROG : SRC_STRAP;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdr_prescaler.sv
module wdr_prescaler #(
    parameter int unsigned SHORT_UNIT_CYC = 3,
    parameter int unsigned LONG_UNIT_CYC  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic long_unit,
    output logic tick
);
    import wdr_pkg::*;

    localparam int unsigned MAXL = max_u(SHORT_UNIT_CYC, LONG_UNIT_CYC);
    localparam int unsigned PW   = $clog2(MAXL + 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] lim;

    assign lim  = long_unit ? PW'(LONG_UNIT_CYC - 1) : PW'(SHORT_UNIT_CYC - 1);
    assign tick = run && !restart && (pcnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pcnt <= '0;
        end else if (pcnt >= lim) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pcnt == '0)) else $error("prescaler did not wrap"); // R3

endmodule

// File: rtl/wdr_countdown.sv
module wdr_countdown #(
    parameter int unsigned TMO_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_en,
    input  logic             start,
    input  logic             tick,
    input  logic [TMO_W-1:0] tmo_val,
    output logic             running,
    output logic             expire
);
    import wdr_pkg::*;

    cd_state_e        state;
    logic [TMO_W-1:0] cnt;

    assign running = (state == CD_RUN);
    assign expire  = wd_en && running && !start && tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CD_IDLE;
            cnt   <= '0;
        end else if (!wd_en) begin
            state <= CD_IDLE;
            cnt   <= tmo_val;
        end else begin
            unique case (state)
                CD_IDLE: begin
                    if (start) begin
                        state <= CD_RUN;
                        cnt   <= tmo_val;
                    end
                end
                CD_RUN: begin
                    if (start) begin
                        cnt <= tmo_val;
                    end else if (tick) begin
                        if (cnt == '0) begin
                            state <= CD_HOLD;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                default: state <= CD_HOLD;
            endcase
        end
    end

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire) else $error("expiry repeated"); // R3
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> (state == CD_IDLE)) else $error("timer not stopped"); // R8
    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        (state == CD_IDLE && !start) |=> (state != CD_RUN)) else $error("ran without change"); // R2

endmodule

// File: rtl/wdr_recovery.sv
module wdr_recovery #(
    parameter int unsigned RST_PULSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wd_en,
    input  logic       expire,
    input  logic       rst_on_expire,
    input  logic       recov_from_regs,
    input  logic       stat_wr,
    input  logic       stat_wdata,
    output logic       status,
    output logic       locked,
    output logic [1:0] src,
    output logic       rst_req
);
    import wdr_pkg::*;

    localparam int unsigned PCW = $clog2(RST_PULSE_CYC + 1);

    recov_state_t   st;
    logic [PCW-1:0] pulse_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.status <= 1'b0;
            st.locked <= 1'b0;
            st.src    <= SRC_NORMAL;
        end else begin
            if (expire) begin
                st.status <= 1'b1;
            end else if (stat_wr && stat_wdata) begin
                st.status <= 1'b0;
            end
            if (!wd_en) begin
                st.locked <= 1'b0;
                st.src    <= SRC_NORMAL;
            end else if (expire) begin
                st.locked <= 1'b1;
                st.src    <= pick_recovery(recov_from_regs);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_cnt <= '0;
        end else if (expire && rst_on_expire) begin
            pulse_cnt <= PCW'(RST_PULSE_CYC);
        end else if (pulse_cnt != '0) begin
            pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    assign status  = st.status;
    assign locked  = st.locked;
    assign src     = st.src;
    assign rst_req = (pulse_cnt != '0);

    AST_EXPIRE_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        expire |=> status) else $error("status not set"); // R4
    AST_RST_GATED: assert property (@(posedge clk) disable iff (rst)
        (!rst_req && !(expire && rst_on_expire)) |=> !rst_req) else $error("stray reset"); // R5
    AST_LOCK_SRC: assert property (@(posedge clk) disable iff (rst)
        locked |-> (src != SRC_NORMAL)) else $error("locked with normal source"); // R6
    AST_UNLOCK_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> !locked) else $error("lock held"); // R8

endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog #(
    parameter int unsigned TMO_W          = 5,
    parameter int unsigned SHORT_UNIT_CYC = 2147727,
    parameter int unsigned LONG_UNIT_CYC  = 35795450,
    parameter int unsigned RST_PULSE_CYC  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_en,
    input  logic             long_unit,
    input  logic [TMO_W-1:0] tmo_val,
    input  logic             rst_on_expire,
    input  logic             recov_from_regs,
    input  logic             chg_req,
    input  logic             stat_wr,
    input  logic             stat_wdata,
    output logic             chg_go,
    output logic             tmo_status,
    output logic             rst_req,
    output logic             recov_lock,
    output logic [1:0]       freq_src
);
    logic start;
    logic running;
    logic tick;
    logic expire;

    assign chg_go = chg_req && !recov_lock;
    assign start  = chg_go && wd_en;

    wdr_prescaler #(
        .SHORT_UNIT_CYC (SHORT_UNIT_CYC),
        .LONG_UNIT_CYC  (LONG_UNIT_CYC)
    ) u_presc (
        .clk       (clk),
        .rst       (rst),
        .run       (running),
        .restart   (start),
        .long_unit (long_unit),
        .tick      (tick)
    );

    wdr_countdown #(
        .TMO_W (TMO_W)
    ) u_cd (
        .clk     (clk),
        .rst     (rst),
        .wd_en   (wd_en),
        .start   (start),
        .tick    (tick),
        .tmo_val (tmo_val),
        .running (running),
        .expire  (expire)
    );

    wdr_recovery #(
        .RST_PULSE_CYC (RST_PULSE_CYC)
    ) u_rec (
        .clk             (clk),
        .rst             (rst),
        .wd_en           (wd_en),
        .expire          (expire),
        .rst_on_expire   (rst_on_expire),
        .recov_from_regs (recov_from_regs),
        .stat_wr         (stat_wr),
        .stat_wdata      (stat_wdata),
        .status          (tmo_status),
        .locked          (recov_lock),
        .src             (freq_src),
        .rst_req         (rst_req)
    );

    AST_LOCK_REFUSES: assert property (@(posedge clk) disable iff (rst)
        recov_lock |-> !chg_go) else $error("change accepted while locked"); // R7
    AST_EN_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        (!wd_en && !tmo_status) |=> !tmo_status) else $error("status set while disabled"); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tmo_status && !recov_lock && !rst_req)) else $error("reset state wrong"); // R1

endmodule

// File: tb/sim_freq_watchdog.sv
module sim_freq_watchdog;
    localparam int SHORT = 3;
    localparam int LONG  = 5;
    localparam int PULSE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wd_en = 1'b0, long_unit = 1'b0, rst_on_expire = 1'b0, recov_from_regs = 1'b0;
    logic chg_req = 1'b0, stat_wr = 1'b0, stat_wdata = 1'b0;
    logic [4:0] tmo_val = 5'd0;
    logic chg_go, tmo_status, rst_req, recov_lock;
    logic [1:0] freq_src;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    freq_watchdog #(
        .TMO_W (5), .SHORT_UNIT_CYC (SHORT), .LONG_UNIT_CYC (LONG), .RST_PULSE_CYC (PULSE)
    ) u0 (
        .clk (clk), .rst (rst), .wd_en (wd_en), .long_unit (long_unit), .tmo_val (tmo_val),
        .rst_on_expire (rst_on_expire), .recov_from_regs (recov_from_regs),
        .chg_req (chg_req), .stat_wr (stat_wr), .stat_wdata (stat_wdata),
        .chg_go (chg_go), .tmo_status (tmo_status), .rst_req (rst_req),
        .recov_lock (recov_lock), .freq_src (freq_src)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_change();
        chg_req = 1'b1;
        step();
        chg_req = 1'b0;
    endtask

    task automatic status_write(input logic d);
        stat_wr = 1'b1;
        stat_wdata = d;
        step();
        stat_wr = 1'b0;
        stat_wdata = 1'b0;
    endtask

    // Count edges after the accepted change until status rises
    task automatic wait_status(input int lim, output int k);
        k = 0;
        while (!tmo_status && k < lim) begin
            step();
            k++;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
                finish_run();
            end
        end
    end

    initial begin
        int k;
        int n;
        @(negedge clk);
        step(); step(); step();
        rst = 1'b0;
        // R1 reset state
        check(tmo_status == 1'b0, "R1 status", tmo_status, 0);
        check(recov_lock == 1'b0, "R1 lock", recov_lock, 0);
        check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
        check(freq_src == 2'b00, "R1 src", freq_src, 0);
        chg_req = 1'b1;
        #0;
        check(chg_go == 1'b1, "R1 go", chg_go, 1);
        chg_req = 1'b0;

        // R2: change while disabled, then enabled with no change
        tmo_val = 5'd0;
        pulse_change();
        for (int i = 0; i < 200; i++) step();
        check(tmo_status == 1'b0, "R2 disabled change", tmo_status, 0);
        wd_en = 1'b1;
        for (int i = 0; i < 200; i++) step();
        check(tmo_status == 1'b0, "R2 no change", tmo_status, 0);

        // R3..R8 sweep over every value and both units
        for (int lu = 0; lu < 2; lu++) begin
            for (int v = 0; v < 32; v++) begin
                int unit;
                unit = (lu != 0) ? LONG : SHORT;
                tmo_val = 5'(v);
                long_unit = lu[0];
                rst_on_expire = v[0];
                recov_from_regs = v[1];
                pulse_change();
                wait_status(200, k);
                check(k == (v + 1) * unit, "R3 expiry time", k, (v + 1) * unit);
                check(rst_req == v[0], "R5 rst_req at expiry", rst_req, v[0]);
                n = 0;
                while (rst_req && n < 50) begin
                    step();
                    n++;
                end
                check(n == (v[0] ? PULSE : 0), "R5 pulse width", n, v[0] ? PULSE : 0);
                check(freq_src == (v[1] ? 2'b11 : 2'b10), "R6 source", freq_src, v[1] ? 3 : 2);
                check(recov_lock == 1'b1, "R7 lock", recov_lock, 1);
                chg_req = 1'b1;
                #0;
                check(chg_go == 1'b0, "R7 refused", chg_go, 0);
                chg_req = 1'b0;
                status_write(1'b0);
                check(tmo_status == 1'b1, "R4 write0 ignored", tmo_status, 1);
                wd_en = 1'b0;
                step();
                check(recov_lock == 1'b0, "R8 unlock", recov_lock, 0);
                check(freq_src == 2'b00, "R8 source normal", freq_src, 0);
                check(tmo_status == 1'b1, "R8 status kept", tmo_status, 1);
                status_write(1'b1);
                check(tmo_status == 1'b0, "R4 write1 clears", tmo_status, 0);
                wd_en = 1'b1;
            end
        end

        // R9: enable cleared in the expiry cycle
        tmo_val = 5'd0;
        long_unit = 1'b0;
        rst_on_expire = 1'b1;
        pulse_change();
        step();
        step();
        wd_en = 1'b0;
        step();
        check(tmo_status == 1'b0, "R9 no status", tmo_status, 0);
        check(recov_lock == 1'b0, "R9 no lock", recov_lock, 0);
        check(rst_req == 1'b0, "R9 no reset", rst_req, 0);
        wd_en = 1'b1;
        for (int i = 0; i < 30; i++) step();
        check(tmo_status == 1'b0, "R9 timer reloaded idle", tmo_status, 0);

        // R10: restart mid-count
        tmo_val = 5'd3;
        pulse_change();
        for (int i = 0; i < 6; i++) step();
        check(tmo_status == 1'b0, "R10 still counting", tmo_status, 0);
        pulse_change();
        wait_status(200, k);
        check(k == 4 * SHORT, "R10 restarted interval", k, 4 * SHORT);

        finish_run();
    end
endmodule